// File: doc/BRIEF.md
# Two-Stage Attack/Hold Note Sequencer

This block times one solenoid note. A note-on strobe captures a 16-bit attack duration and a 16-bit hold-start delay, each supplied as a coarse byte and a fine byte. It raises the attack output at once. The block then places the two timed events, attack release and hold start, in time order. It splits the time into two back-to-back stages. Each stage counts whole 256-tick periods first and then a remainder of single ticks. Ticks come from a prescaler whose division is chosen by a small code. A note-off ends everything at once.

The hold itself is produced by a separate PWM generator. This block only issues one-cycle start and stop strobes to that generator, and it reports attack and hold activity as two state bits.

The controller has five states. SQ_IDLE waits for a note. SQ_S1_COARSE and SQ_S1_FINE count stage 1. SQ_S2_COARSE and SQ_S2_FINE count stage 2. The transitions are as follows:
- note-on goes from any state to SQ_S1_COARSE, or to SQ_S1_FINE when the stage-1 coarse value is zero.
- coarse-done goes from a coarse state to the fine state of the same stage.
- stage1-done goes from SQ_S1_FINE to SQ_S2_COARSE, or to SQ_S2_FINE when the stage-2 coarse value is zero.
- stage2-done goes from SQ_S2_FINE to SQ_IDLE.
- note-off goes from any state to SQ_IDLE, and it has priority over note-on.

Top module: `note_seq_top`

## Requirements
- R1: After reset, attack_out is 0, state_bits is 0, hold_start and hold_stop are 0, and the prescale code is 4.
- R2: On a note-on without note-off, attack_out goes to 1 and state_bits[1] goes to 0 at the next edge, and the sequence restarts from stage 1. If a hold was running, hold_stop pulses at that same edge.
- R3: When the attack count A (coarse*256+fine) is greater than the delay count D, hold_start pulses after A−D ticks and attack_out falls after A ticks.
- R4: When A is less than or equal to D, attack_out falls after A ticks and hold_start pulses after D ticks.
- R5: Each stage lasts coarse*256 ticks plus its fine ticks. The coarse phase of either stage is skipped when its coarse value is 0.
- R6: A fine value of 0 ends its phase on the next tick. So A=D gives the hold start one tick after the release, and A=D=0 gives the release at tick 1 and the hold at tick 2.
- R7: Prescale codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. A code is taken only when load_prescale is high during a note-on. Codes 0, 6 and 7 are ignored. The prescaler restarts on every note-on, so an event after N ticks lands N*division clocks after the note-on edge.
- R8: A note-off at any time clears attack_out and state_bits[1] at the next edge and pulses hold_stop. No later event occurs until the next note-on.
- R9: state_bits[0] follows attack_out, and state_bits[1] is set when hold_start pulses. hold_start and hold_stop are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| note_on | input | 1 | Start strobe; captures the durations |
| note_off | input | 1 | Stop strobe; has priority over note_on |
| load_prescale | input | 1 | With note_on, takes prescale_code |
| prescale_code | input | 3 | Tick division code (1 to 5) |
| attack_coarse | input | 8 | Attack duration, 256-tick units |
| attack_fine | input | 8 | Attack duration, single ticks |
| delay_coarse | input | 8 | Hold-start delay, 256-tick units |
| delay_fine | input | 8 | Hold-start delay, single ticks |
| attack_out | output | 1 | Attack drive |
| hold_start | output | 1 | One-cycle strobe to start the hold PWM |
| hold_stop | output | 1 | One-cycle strobe to stop the hold PWM |
| state_bits | output | 2 | Bit 0 attack active, bit 1 hold running |

## Verification
On every cycle the assertions check the strobe and state-bit relations: note-off clears the outputs and pulses hold_stop, note-on raises attack, the two strobes never clash, and a hold start both sets the hold bit and lasts one cycle. Only the directed scenarios show the exact event times. These cover the two orderings, coarse skipping, zero fine counts, the prescale divisions, ignored codes, and the silence that follows a note-off. Each scenario compares the measured times with times the bench works out from A, D and the division.

// File: rtl/note_seq_pkg.sv
package note_seq_pkg;

    localparam int DIV_CNT_W = 10;
    localparam int BYTE_W    = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_S1_COARSE,
        SQ_S1_FINE,
        SQ_S2_COARSE,
        SQ_S2_FINE
    } seq_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] coarse;
        logic [BYTE_W-1:0] fine;
    } span_t;

    // Terminal count of the prescaler for a valid code (division minus one)
    function automatic logic [DIV_CNT_W-1:0] div_limit(input logic [2:0] code);
        logic [DIV_CNT_W-1:0] lim;
        unique case (code)
            3'd2:    lim = DIV_CNT_W'(7);
            3'd3:    lim = DIV_CNT_W'(63);
            3'd4:    lim = DIV_CNT_W'(255);
            3'd5:    lim = DIV_CNT_W'(1023);
            default: lim = '0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import note_seq_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'd4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       load,
    input  logic [2:0] code_in,
    output logic       tick
);
    logic [2:0]           code_q;
    logic [DIV_CNT_W-1:0] cnt_q;
    logic                 code_ok;

    assign code_ok = (code_in >= 3'd1) && (code_in <= 3'd5);
    assign tick    = (cnt_q == div_limit(code_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RESET_CODE;
            cnt_q  <= '0;
        end else begin
            if (restart && load && code_ok)
                code_q <= code_in;
            if (restart || tick)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/stage_planner.sv
module stage_planner
    import note_seq_pkg::*;
(
    input  span_t attack_in,
    input  span_t delay_in,
    output span_t stage1,
    output span_t stage2,
    output logic  hold_first
);
    logic [2*BYTE_W-1:0] atk, dly;

    assign atk = attack_in;
    assign dly = delay_in;

    always_comb begin
        if (atk > dly) begin
            hold_first = 1'b1;
            stage1     = span_t'(atk - dly);
            stage2     = span_t'(dly);
        end else begin
            hold_first = 1'b0;
            stage1     = span_t'(atk);
            stage2     = span_t'(dly - atk);
        end
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import note_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  note_on,
    input  logic  note_off,
    input  logic  tick,
    input  span_t stage1_in,
    input  span_t stage2_in,
    input  logic  hold_first_in,
    output logic  attack_out,
    output logic  hold_start,
    output logic  hold_stop,
    output logic  hold_active
);
    seq_state_t        state_q, state_d;
    span_t             s1_q, s2_q;
    logic              hf_q;
    logic [BYTE_W-1:0] tk_q, per_q;
    logic [BYTE_W-1:0] cur_coarse, cur_fine;
    logic              period_done, coarse_done, fine_done;
    logic              s1_end, s2_end, is_coarse;

    always_comb begin
        cur_coarse = s2_q.coarse;
        cur_fine   = s2_q.fine;
        if (state_q == SQ_S1_COARSE || state_q == SQ_S1_FINE) begin
            cur_coarse = s1_q.coarse;
            cur_fine   = s1_q.fine;
        end
    end

    assign is_coarse   = (state_q == SQ_S1_COARSE) || (state_q == SQ_S2_COARSE);
    assign period_done = tick && (tk_q == {BYTE_W{1'b1}});
    assign coarse_done = period_done && ((per_q + 1'b1) == cur_coarse);
    assign fine_done   = tick && ((cur_fine == '0) || (tk_q == (cur_fine - 1'b1)));
    assign s1_end      = (state_q == SQ_S1_FINE) && fine_done;
    assign s2_end      = (state_q == SQ_S2_FINE) && fine_done;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (note_off) begin
            state_d = SQ_IDLE;
        end else if (note_on) begin
            state_d = (stage1_in.coarse != '0) ? SQ_S1_COARSE : SQ_S1_FINE;
        end else begin
            unique case (state_q)
                SQ_IDLE:      state_d = SQ_IDLE;
                SQ_S1_COARSE: if (coarse_done) state_d = SQ_S1_FINE;
                SQ_S1_FINE:   if (fine_done)
                                  state_d = (s2_q.coarse != '0) ? SQ_S2_COARSE : SQ_S2_FINE;
                SQ_S2_COARSE: if (coarse_done) state_d = SQ_S2_FINE;
                SQ_S2_FINE:   if (fine_done) state_d = SQ_IDLE;
                default:      state_d = SQ_IDLE;
            endcase
        end
    end

    // State register, captured spans and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            s1_q    <= '0;
            s2_q    <= '0;
            hf_q    <= 1'b0;
            tk_q    <= '0;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            if (note_on && !note_off) begin
                s1_q <= stage1_in;
                s2_q <= stage2_in;
                hf_q <= hold_first_in;
            end
            if (note_on || note_off || (state_d != state_q)) begin
                tk_q  <= '0;
                per_q <= '0;
            end else if (tick && state_q != SQ_IDLE) begin
                tk_q <= tk_q + 1'b1;
                if (is_coarse && period_done)
                    per_q <= per_q + 1'b1;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attack_out  <= 1'b0;
            hold_active <= 1'b0;
            hold_start  <= 1'b0;
            hold_stop   <= 1'b0;
        end else begin
            hold_start <= 1'b0;
            hold_stop  <= 1'b0;
            if (note_off) begin
                attack_out  <= 1'b0;
                hold_active <= 1'b0;
                hold_stop   <= 1'b1;
            end else if (note_on) begin
                attack_out  <= 1'b1;
                hold_active <= 1'b0;
                hold_stop   <= hold_active;
            end else if ((s1_end && hf_q) || (s2_end && !hf_q)) begin
                hold_start  <= 1'b1;
                hold_active <= 1'b1;
            end else if (s1_end || s2_end) begin
                attack_out  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/note_seq_top.sv
module note_seq_top
    import note_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       note_on,
    input  logic       note_off,
    input  logic       load_prescale,
    input  logic [2:0] prescale_code,
    input  logic [7:0] attack_coarse,
    input  logic [7:0] attack_fine,
    input  logic [7:0] delay_coarse,
    input  logic [7:0] delay_fine,
    output logic       attack_out,
    output logic       hold_start,
    output logic       hold_stop,
    output logic [1:0] state_bits
);
    logic  tick, hold_first, hold_active;
    span_t atk_span, dly_span, st1, st2;

    assign atk_span = '{coarse: attack_coarse, fine: attack_fine};
    assign dly_span = '{coarse: delay_coarse,  fine: delay_fine};

    tick_prescaler #(.RESET_CODE(3'd4)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (note_on && !note_off),
        .load    (load_prescale),
        .code_in (prescale_code),
        .tick    (tick)
    );

    stage_planner u_plan (
        .attack_in  (atk_span),
        .delay_in   (dly_span),
        .stage1     (st1),
        .stage2     (st2),
        .hold_first (hold_first)
    );

    seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .note_on       (note_on),
        .note_off      (note_off),
        .tick          (tick),
        .stage1_in     (st1),
        .stage2_in     (st2),
        .hold_first_in (hold_first),
        .attack_out    (attack_out),
        .hold_start    (hold_start),
        .hold_stop     (hold_stop),
        .hold_active   (hold_active)
    );

    assign state_bits = {hold_active, attack_out};
endmodule

// File: rtl/note_seq_chk.sv
module note_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       note_on,
    input logic       note_off,
    input logic       attack_out,
    input logic       hold_start,
    input logic       hold_stop,
    input logic [1:0] state_bits
);
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_start && hold_stop)); // R9

    AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        note_off |=> (!attack_out && !state_bits[1] && hold_stop)); // R8

    AST_ON_ATTACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (note_on && !note_off) |=> (attack_out && !state_bits[1])); // R2

    AST_START_SETS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_start |-> state_bits[1]); // R9

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_start |=> !hold_start); // R9
endmodule

bind note_seq_top note_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .note_on    (note_on),
    .note_off   (note_off),
    .attack_out (attack_out),
    .hold_start (hold_start),
    .hold_stop  (hold_stop),
    .state_bits (state_bits)
);

// File: tb/tb_note_seq_top.sv
`timescale 1ns/1ps
module tb_note_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       note_on = 1'b0, note_off = 1'b0, load_prescale = 1'b0;
    logic [2:0] prescale_code = 3'd0;
    logic [7:0] attack_coarse = '0, attack_fine = '0, delay_coarse = '0, delay_fine = '0;
    logic       attack_out, hold_start, hold_stop;
    logic [1:0] state_bits;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    note_seq_top dut (
        .clk(clk), .rst_n(rst_n), .note_on(note_on), .note_off(note_off),
        .load_prescale(load_prescale), .prescale_code(prescale_code),
        .attack_coarse(attack_coarse), .attack_fine(attack_fine),
        .delay_coarse(delay_coarse), .delay_fine(delay_fine),
        .attack_out(attack_out), .hold_start(hold_start), .hold_stop(hold_stop),
        .state_bits(state_bits)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ticks_of(input int v);
        int f = v % 256;
        return (v / 256) * 256 + ((f == 0) ? 1 : f);
    endfunction

    // Fire a note-on and wait; records the edge index of the hold start and the attack release
    task automatic fire(input int ac, input int af, input int dc, input int df,
                        input bit ld, input int code, input int limit,
                        output int hold_at, output int rel_at, output int first_bits);
        @(negedge clk);
        attack_coarse = 8'(ac); attack_fine = 8'(af);
        delay_coarse  = 8'(dc); delay_fine  = 8'(df);
        load_prescale = ld; prescale_code = 3'(code); note_on = 1'b1;
        @(posedge clk);
        @(negedge clk);
        note_on = 1'b0; load_prescale = 1'b0;
        first_bits = int'(state_bits);
        hold_at = -1; rel_at = -1;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (hold_start && hold_at < 0) hold_at = n;
            if (!attack_out && rel_at < 0) rel_at = n;
        end
    endtask

    task automatic run_note(input string req, input int ac, input int af, input int dc,
                            input int df, input bit ld, input int code, input int div);
        int a = ac * 256 + af, d = dc * 256 + df;
        int eh, er, h, r, fb;
        if (a > d) begin
            eh = ticks_of(a - d) * div;
            er = eh + ticks_of(d) * div;
        end else begin
            er = ticks_of(a) * div;
            eh = er + ticks_of(d - a) * div;
        end
        fire(ac, af, dc, df, ld, code, ((eh > er) ? eh : er) + 4, h, r, fb);
        chk(fb[0] == 1'b1, {req, " R2 attack"}, fb, 1);
        chk(h == eh, {req, " hold time"}, h, eh);
        chk(r == er, {req, " release time"}, r, er);
        chk(state_bits == 2'b10, {req, " R9 bits"}, int'(state_bits), 2);
    endtask

    task automatic t_reset();
        chk(attack_out == 1'b0 && hold_start == 1'b0 && hold_stop == 1'b0,
            "R1 outputs", int'({attack_out, hold_start, hold_stop}), 0);
        chk(state_bits == 2'b00, "R1 state", int'(state_bits), 0);
    endtask

    task automatic t_note_off();
        int h = -1;
        @(negedge clk);
        attack_coarse = 8'd0; attack_fine = 8'd100; delay_coarse = 8'd0; delay_fine = 8'd20;
        note_on = 1'b1;
        @(negedge clk); note_on = 1'b0;
        repeat (30) @(negedge clk);
        note_off = 1'b1;
        @(negedge clk); note_off = 1'b0;
        chk(!attack_out && hold_stop && state_bits == 2'b00, "R8 off",
            int'({attack_out, hold_stop, state_bits}), 4);
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if ((hold_start || attack_out) && h < 0) h = n;
        end
        chk(h < 0, "R8 silent after off", h, -1);
    endtask

    task automatic t_retrigger();
        int h, r, fb;
        run_note("R3 pre-retrigger", 0, 2, 0, 1, 1'b0, 0, 1);
        fire(0, 5, 0, 9, 1'b0, 0, 1, h, r, fb);
        chk(fb == 1, "R2 retrigger bits", fb, 1);
        chk(hold_stop == 1'b0, "R2 stop is one pulse", int'(hold_stop), 0);
        @(negedge clk); note_off = 1'b1; @(negedge clk); note_off = 1'b0;
    endtask

    task automatic t_retrigger_stop();
        int h, r, fb;
        run_note("R3 hold up", 0, 3, 0, 1, 1'b0, 0, 1);
        @(negedge clk);
        note_on = 1'b1;
        @(posedge clk); @(negedge clk); note_on = 1'b0;
        chk(hold_stop == 1'b1, "R2 stop on retrigger", int'(hold_stop), 1);
        fire(0, 1, 0, 0, 1'b0, 0, 4, h, r, fb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_note("R7 default code", 0, 1, 0, 0, 1'b0, 1, 256);
        run_note("R3 hold first", 1, 44, 0, 100, 1'b1, 1, 1);
        run_note("R4 release first R5", 0, 50, 2, 88, 1'b0, 0, 1);
        run_note("R5 coarse both", 2, 10, 1, 5, 1'b0, 0, 1);
        run_note("R6 equal", 0, 10, 0, 10, 1'b0, 0, 1);
        run_note("R6 zero", 0, 0, 0, 0, 1'b0, 0, 1);
        run_note("R7 div8", 0, 5, 0, 3, 1'b1, 2, 8);
        run_note("R7 invalid ignored", 0, 5, 0, 3, 1'b1, 0, 8);
        run_note("R7 div64", 0, 2, 0, 1, 1'b1, 3, 64);
        run_note("R7 div1 again", 0, 4, 0, 7, 1'b1, 1, 1);
        t_note_off();
        t_retrigger_stop();
        t_retrigger();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule